// File: doc/BRIEF.md
# Lite Serial Port with Register Window

A small asynchronous serial port that a processor reaches through four 32-bit word registers in a 16-byte window. Characters written to the send register enter a 16-deep send queue. A serializer drains that queue and puts each character on the line as a frame: one low start bit, the data bits least significant first, an optional parity bit and one high stop bit. Characters arriving on the receive line are sampled with a 16x oversampling counter, checked, and stored in a 16-deep receive queue. Software pops that queue by reading the receive register.

The data width (5 to 8 bits), parity enable, odd or even parity and the bit rate are build-time parameters. Nothing about the frame can be changed at run time. Each bit lasts 16 × `OS_DIV` clock cycles. A status register packs the queue levels, the interrupt enable and three sticky error flags into one byte. A control write can empty either queue and sets the interrupt enable. A single interrupt line gives one-cycle pulses, meant to be taken as edge events.

The serializer steps through the states TX_IDLE, TX_START, TX_DATA, TX_PARITY and TX_STOP. From TX_IDLE it moves to TX_START when the send queue holds a character, which it pops. TX_START goes to TX_DATA after one bit time. TX_DATA goes to TX_PARITY after the last data bit, or to TX_STOP when parity is off. TX_PARITY goes to TX_STOP, and TX_STOP goes back to TX_IDLE, each after one bit time. The receiver steps through the states RX_IDLE, RX_START, RX_DATA, RX_PARITY and RX_STOP. RX_IDLE goes to RX_START on a falling edge of the synchronized line. At the 8th oversample tick, RX_START goes to RX_DATA if the line is still low, and back to RX_IDLE if it is not. Every later bit is sampled 16 ticks after the previous sample. RX_DATA goes to RX_PARITY, or to RX_STOP when parity is off, after the last data bit. RX_PARITY goes to RX_STOP. RX_STOP goes to RX_IDLE after the stop sample.

Top module: `lite_uart`

## Requirements
- R1: Address bits [3:2] select the register: 0 is receive data (read), 1 is send data (write), 2 is status (read) and 3 is control (write). Read data appears on `bus_rdata` one cycle after the read strobe. A read of register 0 returns the oldest received character in bits [7:0] and removes it from the queue.
- R2: The status byte holds: bit0 receive data available, bit1 receive queue full, bit2 send queue empty, bit3 send queue full, bit4 interrupt enabled, bit5 overrun, bit6 framing error, bit7 parity error. Bits [31:8] read as zero.
- R3: A read of the receive register while the receive queue is empty returns 0 and changes no state.
- R4: Only bits [7:0] of a send write are used. A send write while 16 characters are queued is dropped.
- R5: Each sent frame is a low start bit, the data bits LSB first, an even parity bit (the default build), then one high stop bit. Every bit lasts exactly 16 × OS_DIV cycles. The line idles high.
- R6: The receiver samples each bit at its midpoint. A start bit that is high again at its midpoint is discarded and nothing is stored.
- R7: A stop bit sampled low sets the framing error flag, and the character is not stored.
- R8: A character with wrong parity is stored and sets the parity error flag.
- R9: A character that completes while the receive queue holds 16 entries is discarded and sets the overrun flag.
- R10: The three error flags stay set until a status read. A status read returns their values and then clears them.
- R11: A control write with bit0 set empties the send queue, so the next status read shows send-empty. Bit1 set empties the receive queue. Bit4 is copied to the interrupt enable, so a write of 0 disables interrupts.
- R12: While interrupts are enabled, `irq` is high for exactly one cycle when the receive queue goes from empty to non-empty. It also pulses for one cycle when a frame finishes with the send queue empty. With interrupts disabled it stays low.
- R13: After reset `txd` is high, `irq` is low and the status byte is 0x04.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 4 | Byte address inside the window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| uart_rxd | input | 1 | Serial receive line |
| uart_txd | output | 1 | Serial send line |
| irq | output | 1 | Interrupt pulse |

## Verification
The checker watches every cycle for these rules:
- `irq` never stays high for two cycles and never fires without the enable.
- A send-queue clear leaves the queue empty, and so does a receive-queue clear.
- A framed-out or overrun character never changes the receive level, and overrun raises its flag.
- Error flags hold until a status read.
- An empty receive read returns zero.

Some behaviour only the bench scenarios can show. These are the exact line waveform of each frame, compared clock by clock against the bench model, and mid-bit rejection of a short start glitch. They also include the values of stored and dropped characters across a full queue, and the status byte after each sequence.

// File: rtl/lite_uart_pkg.sv
package lite_uart_pkg;
    localparam logic [1:0] REG_RXD  = 2'd0;
    localparam logic [1:0] REG_TXD  = 2'd1;
    localparam logic [1:0] REG_STAT = 2'd2;
    localparam logic [1:0] REG_CTRL = 2'd3;

    localparam int CT_TXCLR = 0;
    localparam int CT_RXCLR = 1;
    localparam int CT_IE    = 4;

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_PARITY, TX_STOP
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PARITY, RX_STOP
    } rx_state_e;
endpackage

// File: rtl/lite_uart_fifo.sv
module lite_uart_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int PW = $clog2(DEPTH),
    localparam int LW = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [LW-1:0]    level,
    output logic             empty,
    output logic             full
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign empty   = (level == '0);
    assign full    = (level == LW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/lite_uart_tx.sv
module lite_uart_tx
    import lite_uart_pkg::*;
#(
    parameter int OS_DIV     = 4,
    parameter int DATA_BITS  = 8,
    parameter bit PARITY_EN  = 1'b1,
    parameter bit PARITY_ODD = 1'b0,
    localparam int BIT_CLKS = 16 * OS_DIV,
    localparam int TW = $clog2(BIT_CLKS)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fifo_empty,
    input  logic [7:0] fifo_dout,
    output logic       fifo_pop,
    output logic       txd,
    output logic       frame_done
);
    tx_state_e              state, nstate;
    logic [TW-1:0]          timer;
    logic [2:0]             bitn;
    logic [DATA_BITS-1:0]   shreg;
    logic                   par_bit;
    logic                   bit_end;

    assign bit_end    = (timer == TW'(BIT_CLKS - 1));
    assign fifo_pop   = (state == TX_IDLE) && !fifo_empty;
    assign frame_done = (state == TX_STOP) && bit_end;

    always_comb begin
        nstate = state;
        unique case (state)
            TX_IDLE:   if (!fifo_empty) nstate = TX_START;
            TX_START:  if (bit_end) nstate = TX_DATA;
            TX_DATA:   if (bit_end && bitn == 3'(DATA_BITS - 1))
                           nstate = PARITY_EN ? TX_PARITY : TX_STOP;
            TX_PARITY: if (bit_end) nstate = TX_STOP;
            TX_STOP:   if (bit_end) nstate = TX_IDLE;
            default:   nstate = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= nstate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timer   <= '0;
            bitn    <= '0;
            shreg   <= '0;
            par_bit <= 1'b0;
        end else if (state == TX_IDLE) begin
            timer <= '0;
            bitn  <= '0;
            if (fifo_pop) begin
                shreg   <= fifo_dout[DATA_BITS-1:0];
                par_bit <= (^fifo_dout[DATA_BITS-1:0]) ^ PARITY_ODD;
            end
        end else begin
            timer <= bit_end ? '0 : timer + 1'b1;
            if (state == TX_DATA && bit_end) begin
                shreg <= shreg >> 1;
                bitn  <= bitn + 1'b1;
            end
        end
    end

    always_comb begin
        unique case (state)
            TX_START:  txd = 1'b0;
            TX_DATA:   txd = shreg[0];
            TX_PARITY: txd = par_bit;
            default:   txd = 1'b1;
        endcase
    end
endmodule

// File: rtl/lite_uart_rx.sv
module lite_uart_rx
    import lite_uart_pkg::*;
#(
    parameter int OS_DIV     = 4,
    parameter int DATA_BITS  = 8,
    parameter bit PARITY_EN  = 1'b1,
    parameter bit PARITY_ODD = 1'b0,
    localparam int DW = (OS_DIV > 1) ? $clog2(OS_DIV) : 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rxd,
    output logic       done,
    output logic [7:0] data,
    output logic       ferr,
    output logic       perr
);
    rx_state_e            state, nstate;
    logic                 sync1, sync2, prev;
    logic                 fall, tick, samp, mid_start;
    logic [DW-1:0]        div;
    logic [3:0]           os_cnt;
    logic [2:0]           bitn;
    logic [DATA_BITS-1:0] shreg;
    logic                 par_rx;
    logic                 perr_c;

    assign fall      = prev && !sync2;
    assign tick      = (div == DW'(OS_DIV - 1));
    assign mid_start = tick && (os_cnt == 4'd7);
    assign samp      = tick && (os_cnt == 4'd15);
    assign data      = 8'(shreg);

    generate
        if (PARITY_EN) begin : g_par
            assign perr_c = (^shreg) ^ PARITY_ODD ^ par_rx;
        end else begin : g_nopar
            assign perr_c = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
            prev  <= 1'b1;
        end else begin
            sync1 <= rxd;
            sync2 <= sync1;
            prev  <= sync2;
        end
    end

    always_comb begin
        nstate = state;
        unique case (state)
            RX_IDLE:   if (fall) nstate = RX_START;
            RX_START:  if (mid_start) nstate = sync2 ? RX_IDLE : RX_DATA;
            RX_DATA:   if (samp && bitn == 3'(DATA_BITS - 1))
                           nstate = PARITY_EN ? RX_PARITY : RX_STOP;
            RX_PARITY: if (samp) nstate = RX_STOP;
            RX_STOP:   if (samp) nstate = RX_IDLE;
            default:   nstate = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nstate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div    <= '0;
            os_cnt <= '0;
            bitn   <= '0;
            shreg  <= '0;
            par_rx <= 1'b0;
        end else if (state == RX_IDLE) begin
            div    <= '0;
            os_cnt <= '0;
            bitn   <= '0;
        end else begin
            div <= tick ? '0 : div + 1'b1;
            if (tick) begin
                if (state == RX_START && os_cnt == 4'd7) os_cnt <= '0;
                else                                     os_cnt <= os_cnt + 1'b1;
            end
            if (state == RX_DATA && samp) begin
                shreg <= {sync2, shreg[DATA_BITS-1:1]};
                bitn  <= bitn + 1'b1;
            end
            if (state == RX_PARITY && samp) par_rx <= sync2;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done <= 1'b0;
            ferr <= 1'b0;
            perr <= 1'b0;
        end else begin
            done <= (state == RX_STOP) && samp;
            ferr <= (state == RX_STOP) && samp && !sync2;
            perr <= (state == RX_STOP) && samp && perr_c;
        end
    end
endmodule

// File: rtl/lite_uart.sv
module lite_uart
    import lite_uart_pkg::*;
#(
    parameter int OS_DIV     = 4,
    parameter int DATA_BITS  = 8,
    parameter bit PARITY_EN  = 1'b1,
    parameter bit PARITY_ODD = 1'b0,
    parameter int FIFO_DEPTH = 16,
    localparam int LW = $clog2(FIFO_DEPTH) + 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        uart_rxd,
    output logic        uart_txd,
    output logic        irq
);
    logic [1:0]    reg_idx;
    logic          rx_pop, rx_push, rx_clr, rx_empty, rx_full;
    logic          tx_pop, tx_push, tx_clr, tx_empty, tx_full;
    logic [7:0]    rx_dout, tx_dout;
    logic [LW-1:0] rx_level, tx_level;
    logic          stat_rd, wr_ctl;
    logic          rxe_done, rxe_ferr, rxe_perr;
    logic [7:0]    rxe_data;
    logic          tx_done;
    logic          ie_q, err_ovr_q, err_frm_q, err_par_q, rx_was_empty;
    logic [7:0]    status;
    logic          unused_bits;

    assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:8]};

    assign reg_idx = bus_addr[3:2];
    assign rx_pop  = bus_rd && reg_idx == REG_RXD && !rx_empty;
    assign stat_rd = bus_rd && reg_idx == REG_STAT;
    assign tx_push = bus_wr && reg_idx == REG_TXD && !tx_full;
    assign wr_ctl  = bus_wr && reg_idx == REG_CTRL;
    assign tx_clr  = wr_ctl && bus_wdata[CT_TXCLR];
    assign rx_clr  = wr_ctl && bus_wdata[CT_RXCLR];
    assign rx_push = rxe_done && !rxe_ferr && !rx_full;

    assign status = {err_par_q, err_frm_q, err_ovr_q, ie_q,
                     tx_full, tx_empty, rx_full, !rx_empty};

    lite_uart_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr), .push(rx_push), .din(rxe_data),
        .pop(rx_pop), .dout(rx_dout), .level(rx_level), .empty(rx_empty),
        .full(rx_full)
    );

    lite_uart_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr), .push(tx_push),
        .din(bus_wdata[7:0]), .pop(tx_pop), .dout(tx_dout), .level(tx_level),
        .empty(tx_empty), .full(tx_full)
    );

    lite_uart_tx #(.OS_DIV(OS_DIV), .DATA_BITS(DATA_BITS),
                   .PARITY_EN(PARITY_EN), .PARITY_ODD(PARITY_ODD)) u_tx (
        .clk(clk), .rst_n(rst_n), .fifo_empty(tx_empty), .fifo_dout(tx_dout),
        .fifo_pop(tx_pop), .txd(uart_txd), .frame_done(tx_done)
    );

    lite_uart_rx #(.OS_DIV(OS_DIV), .DATA_BITS(DATA_BITS),
                   .PARITY_EN(PARITY_EN), .PARITY_ODD(PARITY_ODD)) u_rx (
        .clk(clk), .rst_n(rst_n), .rxd(uart_rxd), .done(rxe_done),
        .data(rxe_data), .ferr(rxe_ferr), .perr(rxe_perr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            unique case (reg_idx)
                REG_RXD:  bus_rdata <= rx_empty ? 32'd0 : {24'd0, rx_dout};
                REG_STAT: bus_rdata <= {24'd0, status};
                default:  bus_rdata <= 32'd0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q         <= 1'b0;
            err_ovr_q    <= 1'b0;
            err_frm_q    <= 1'b0;
            err_par_q    <= 1'b0;
            rx_was_empty <= 1'b1;
            irq          <= 1'b0;
        end else begin
            if (wr_ctl) ie_q <= bus_wdata[CT_IE];
            err_ovr_q    <= (rxe_done && !rxe_ferr && rx_full) || (err_ovr_q && !stat_rd);
            err_frm_q    <= (rxe_done && rxe_ferr) || (err_frm_q && !stat_rd);
            err_par_q    <= (rx_push && rxe_perr) || (err_par_q && !stat_rd);
            rx_was_empty <= rx_empty;
            irq          <= ie_q && ((rx_was_empty && !rx_empty) || (tx_done && tx_empty));
        end
    end
endmodule

// File: rtl/lite_uart_chk.sv
module lite_uart_chk #(
    parameter int DEPTH = 16,
    parameter int LW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [3:0]    bus_addr,
    input logic          bus_rd,
    input logic          bus_wr,
    input logic [31:0]   bus_wdata,
    input logic [31:0]   bus_rdata,
    input logic          irq,
    input logic          ie_q,
    input logic [LW-1:0] rx_level,
    input logic [LW-1:0] tx_level,
    input logic          rx_pop,
    input logic          rx_clr,
    input logic          rxe_done,
    input logic          rxe_ferr,
    input logic          err_ovr_q
);
    logic ctl_wr, st_rd;
    assign ctl_wr = bus_wr && bus_addr[3:2] == 2'd3;
    assign st_rd  = bus_rd && bus_addr[3:2] == 2'd2;

    p_irq_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    p_irq_enable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(ie_q));

    p_tx_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && bus_wdata[0]) |=> (tx_level == '0));

    p_rx_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && bus_wdata[1]) |=> (rx_level == '0));

    p_frame_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rxe_done && rxe_ferr && !rx_pop && !rx_clr) |=> (rx_level == $past(rx_level)));

    p_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rxe_done && !rxe_ferr && rx_level == LW'(DEPTH) && !rx_pop && !rx_clr)
        |=> (err_ovr_q && rx_level == LW'(DEPTH)));

    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_ovr_q && !st_rd) |=> err_ovr_q);

    p_empty_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr[3:2] == 2'd0 && rx_level == '0) |=> (bus_rdata == 32'd0));

    p_level_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level <= LW'(DEPTH)) && (tx_level <= LW'(DEPTH)));
endmodule

bind lite_uart lite_uart_chk #(.DEPTH(FIFO_DEPTH), .LW(LW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .ie_q(ie_q), .rx_level(rx_level), .tx_level(tx_level), .rx_pop(rx_pop),
    .rx_clr(rx_clr), .rxe_done(rxe_done), .rxe_ferr(rxe_ferr),
    .err_ovr_q(err_ovr_q)
);

// File: tb/lite_uart_test.sv
`timescale 1ns/1ps
module lite_uart_test;
    localparam int OS_DIV   = 4;
    localparam int DBITS    = 8;
    localparam int BIT_CLKS = 16 * OS_DIV;
    localparam int NBITS    = 2 + DBITS + 1;
    localparam int FRAME    = NBITS * BIT_CLKS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rxd = 1'b1;
    logic        txd;
    logic        irq;

    int n_chk = 0, n_err = 0;
    int irq_cnt = 0, irq_long = 0;
    int dec_frames = 0, dec_err = 0;
    bit irq_prev = 1'b0;
    bit done = 1'b0;
    logic [7:0] expq [$];

    always #4 clk = ~clk;

    lite_uart uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .uart_rxd(rxd), .uart_txd(txd), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] st(input bit par, frm, ovr, ie, txf, txe, rxf, rxv);
        return {24'd0, par, frm, ovr, ie, txf, txe, rxf, rxv};
    endfunction

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic send_rx(input logic [7:0] d, input bit bad_par, input bit bad_stop);
        logic [NBITS-1:0] fr;
        fr = {~bad_stop, (^d) ^ bad_par, d, 1'b0};
        for (int i = 0; i < NBITS; i++) begin
            rxd = fr[i];
            repeat (BIT_CLKS) @(negedge clk);
        end
        rxd = 1'b1;
        if (bad_stop) repeat (BIT_CLKS) @(negedge clk);
    endtask

    // per-clock model of the send line: each frame compared cycle by cycle
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && txd === 1'b0) begin
                logic [7:0] e;
                logic [NBITS-1:0] fr;
                bit bad;
                bad = 1'b0;
                if (expq.size() == 0) begin bad = 1'b1; e = 8'h00; end
                else e = expq.pop_front();
                fr = {1'b1, ^e, e, 1'b0};
                for (int i = 0; i < FRAME; i++) begin
                    if (i != 0) @(negedge clk);
                    if (txd !== fr[i / BIT_CLKS]) bad = 1'b1;
                end
                dec_frames++;
                if (bad) dec_err++;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (irq && irq_prev) irq_long++;
            if (irq && !irq_prev) irq_cnt++;
        end
        irq_prev = irq;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int i0, f0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R13 txd idle", {31'd0, txd}, 32'd1);
        chk("R13 irq low", {31'd0, irq}, 32'd0);
        bus_read(4'h8, d); chk("R13 R2 reset status", d, st(0,0,0,0,0,1,0,0));

        bus_write(4'hC, 32'h10);
        bus_read(4'h8, d); chk("R11 ie set", d, st(0,0,0,1,0,1,0,0));

        i0 = irq_cnt;
        send_rx(8'h5A, 0, 0); repeat (8) @(negedge clk);
        bus_read(4'h8, d); chk("R2 R6 rx valid", d, st(0,0,0,1,0,1,0,1));
        chk("R12 rx irq pulse", irq_cnt - i0, 1);
        bus_read(4'h0, d); chk("R1 rx data", d, 32'h5A);
        bus_read(4'h8, d); chk("R1 popped", d, st(0,0,0,1,0,1,0,0));

        bus_read(4'h0, d); chk("R3 empty read", d, 0);
        bus_read(4'h8, d); chk("R3 no side effect", d, st(0,0,0,1,0,1,0,0));

        rxd = 1'b0; repeat (BIT_CLKS / 4) @(negedge clk);
        rxd = 1'b1; repeat (3 * BIT_CLKS) @(negedge clk);
        bus_read(4'h8, d); chk("R6 glitch ignored", d, st(0,0,0,1,0,1,0,0));

        send_rx(8'h33, 1, 0); repeat (8) @(negedge clk);
        bus_read(4'h8, d); chk("R8 parity flag", d, st(1,0,0,1,0,1,0,1));
        bus_read(4'h8, d); chk("R10 parity cleared", d, st(0,0,0,1,0,1,0,1));
        bus_read(4'h0, d); chk("R8 char stored", d, 32'h33);

        send_rx(8'h77, 0, 1); repeat (8) @(negedge clk);
        bus_read(4'h8, d); chk("R7 frame flag", d, st(0,1,0,1,0,1,0,0));
        bus_read(4'h8, d); chk("R10 frame cleared", d, st(0,0,0,1,0,1,0,0));

        i0 = irq_cnt;
        for (int k = 0; k < 17; k++) send_rx(8'h40 + 8'(k), 0, 0);
        repeat (8) @(negedge clk);
        bus_read(4'h8, d); chk("R9 overrun full", d, st(0,0,1,1,0,1,1,1));
        chk("R12 one rx irq", irq_cnt - i0, 1);
        for (int k = 0; k < 16; k++) begin
            bus_read(4'h0, d); chk("R9 kept char", d, 32'h40 + k);
        end
        bus_read(4'h8, d); chk("R10 overrun cleared", d, st(0,0,0,1,0,1,0,0));

        send_rx(8'h11, 0, 0); send_rx(8'h22, 0, 0); repeat (8) @(negedge clk);
        bus_read(4'h8, d); chk("R11 rx before clear", d, st(0,0,0,1,0,1,0,1));
        bus_write(4'hC, 32'h12);
        bus_read(4'h8, d); chk("R11 rx cleared", d, st(0,0,0,1,0,1,0,0));
        bus_read(4'h0, d); chk("R11 rx empty read", d, 0);

        i0 = irq_cnt; f0 = dec_frames;
        expq.push_back(8'hA5); expq.push_back(8'h0F); expq.push_back(8'hC3);
        bus_write(4'h4, 32'hA5); bus_write(4'h4, 32'h0F); bus_write(4'h4, 32'h1C3);
        repeat (3 * FRAME + 100) @(negedge clk);
        chk("R5 R4 frames sent", dec_frames - f0, 3);
        chk("R5 line waveform", dec_err, 0);
        chk("R12 tx done irq", irq_cnt - i0, 1);
        bus_read(4'h8, d); chk("R2 tx idle status", d, st(0,0,0,1,0,1,0,0));

        bus_write(4'hC, 32'h0);
        bus_read(4'h8, d); chk("R11 ie off", d, st(0,0,0,0,0,1,0,0));

        i0 = irq_cnt; f0 = dec_frames;
        for (int k = 0; k < 17; k++) expq.push_back(8'h60 + 8'(k));
        for (int k = 0; k < 20; k++) bus_write(4'h4, 32'h60 + k);
        bus_read(4'h8, d); chk("R4 tx full", d, st(0,0,0,0,1,0,0,0));
        repeat (17 * FRAME + 200) @(negedge clk);
        chk("R4 accepted frames", dec_frames - f0, 17);
        chk("R4 R5 waveform", dec_err, 0);
        chk("R12 no irq disabled", irq_cnt - i0, 0);
        bus_read(4'h8, d); chk("R4 drained", d, st(0,0,0,0,0,1,0,0));

        f0 = dec_frames;
        expq.push_back(8'h81);
        for (int k = 0; k < 5; k++) bus_write(4'h4, 32'h81 + k);
        bus_write(4'hC, 32'h01);
        bus_read(4'h8, d); chk("R11 tx empty after clear", d, st(0,0,0,0,0,1,0,0));
        repeat (FRAME + 200) @(negedge clk);
        chk("R11 only shifting char sent", dec_frames - f0, 1);
        chk("R11 waveform", dec_err, 0);
        chk("R11 queue drained", expq.size(), 0);
        chk("R12 pulse width", irq_long, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule